// File: doc/BRIEF.md
# Status-Flag Generating 16-bit ALU

This block is the integer arithmetic unit of a small processor core. It takes two 16-bit operands, an opcode and a byte/word width select, and produces a result at once through combinational logic. Alongside the result it computes five condition bits: carry, zero, negative, signed overflow and a nibble (digit) carry. The bits are kept in a register that updates on the next rising clock edge.

Each opcode updates only its own set of condition bits. The others keep their last value until an operation that owns them runs again. A global update enable can block all flag writes, for example while an instruction is being cancelled. On subtraction, carry and digit carry are reported as inverted borrows.

In byte mode the operation works on the low eight bits only. The upper byte of the result is a copy of operand A, and all condition bits are taken from the low byte.

Top module: `status_alu`

## Requirements
- R1: Opcode 0 (add) gives A+B modulo 2^16 on `result` in the same cycle, and C is set to the carry out of bit 15.
- R2: Opcode 1 (subtract) gives A-B modulo 2^16, and C is set to 1 when no borrow occurs (A >= B unsigned) and to 0 when a borrow occurs.
- R3: For add, OV is set when A and B have the same sign bit and the result sign differs from it. For subtract, OV is set when the sign bits of A and B differ and the result sign differs from A's sign.
- R4: DC is set to the carry out of bit 3 for add and to the inverted borrow out of bit 3 for subtract, in both widths.
- R5: Z is set when the result is zero over the active width, and N is set to the result's top bit of the active width (bit 15 for word, bit 7 for byte).
- R6: When `byte_mode` is 1, bits 7:0 hold the 8-bit operation, bits 15:8 of `result` equal A[15:8], and C and OV are taken at bit 7.
- R7: Opcodes 2, 3 and 4 give A AND B, A OR B and A XOR B, update Z and N only, and leave C, OV and DC unchanged.
- R8: Opcodes 5, 6 and 7 shift A by one place: 5 shifts left with a 0 fill, 6 shifts right logically, and 7 shifts right arithmetically. C takes the bit shifted out, Z and N are updated, and OV and DC are kept.
- R9: The flags change only on the rising clock edge after an operation is applied. When `flag_en` is 0, no flag changes, but `result` is still produced.
- R10: An active-low `rst_n` clears all five flags to 0 asynchronously.
- R11: Opcodes 8 to 15 pass A to `result` unchanged and update no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Asynchronous active-low reset of the flags |
| op_a | input | 16 | Operand A (minuend, shift source) |
| op_b | input | 16 | Operand B |
| opcode | input | 4 | Operation select (see R1, R2, R7, R8, R11) |
| byte_mode | input | 1 | 1 selects the 8-bit operation on the low byte |
| flag_en | input | 1 | 1 lets the operation write its flags |
| result | output | 16 | Combinational result |
| flag_c | output | 1 | Carry / inverted borrow |
| flag_z | output | 1 | Zero |
| flag_n | output | 1 | Negative |
| flag_ov | output | 1 | Signed overflow |
| flag_dc | output | 1 | Digit carry / inverted digit borrow |

## Verification
`result` is combinational, so the bench drives each operation on a falling edge and checks the result one nanosecond later, before any clock edge. The flags pass through one register, so they are checked on the next falling edge, after exactly one rising edge has captured them. The bench keeps its own copy of the flag register and merges in only the bits the opcode owns. Operations that leave flags alone are therefore checked against the value an earlier row left behind.

// File: rtl/status_alu_pkg.sv
package status_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_AND = 4'd2,
    OP_OR  = 4'd3,
    OP_XOR = 4'd4,
    OP_SHL = 4'd5,
    OP_SHR = 4'd6,
    OP_ASR = 4'd7
  } alu_op_e;

  localparam int NFLAGS = 5;
  // bit positions inside the packed flag vector
  localparam int FB_C  = 4;
  localparam int FB_Z  = 3;
  localparam int FB_N  = 2;
  localparam int FB_OV = 1;
  localparam int FB_DC = 0;

  function automatic logic [NFLAGS-1:0] flag_mask(input logic [3:0] op);
    logic [NFLAGS-1:0] m;
    m = '0;
    unique case (op)
      OP_ADD, OP_SUB:         m = '1;
      OP_AND, OP_OR, OP_XOR: begin m[FB_Z] = 1'b1; m[FB_N] = 1'b1; end
      OP_SHL, OP_SHR, OP_ASR: begin
        m[FB_C] = 1'b1; m[FB_Z] = 1'b1; m[FB_N] = 1'b1;
      end
      default:                m = '0;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/alu_decode.sv
module alu_decode
  import status_alu_pkg::*;
(
  input  logic [3:0]        opcode,
  input  logic              flag_en,
  output logic              is_arith,
  output logic              is_sub,
  output logic              is_logic,
  output logic              is_shift,
  output logic [NFLAGS-1:0] upd
);
  always_comb begin
    is_arith = (opcode == OP_ADD) || (opcode == OP_SUB);
    is_sub   = (opcode == OP_SUB);
    is_logic = (opcode == OP_AND) || (opcode == OP_OR) || (opcode == OP_XOR);
    is_shift = (opcode == OP_SHL) || (opcode == OP_SHR) || (opcode == OP_ASR);
    upd      = flag_en ? flag_mask(opcode) : '0;
  end
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic         byte_mode,
  output logic [W-1:0] sum,
  output logic         c_out,
  output logic         ov_out,
  output logic         dc_out
);
  localparam int H  = W / 2;
  localparam int NB = 4;

  logic [W-1:0] bx;
  logic [W:0]   full_s;
  logic [H:0]   half_s;
  logic [NB:0]  nib_s;
  logic         sa, sb, sr;

  always_comb begin
    bx     = sub ? ~b : b;
    full_s = {1'b0, a} + {1'b0, bx} + {{W{1'b0}}, sub};
    half_s = {1'b0, a[H-1:0]} + {1'b0, bx[H-1:0]} + {{H{1'b0}}, sub};
    nib_s  = {1'b0, a[NB-1:0]} + {1'b0, bx[NB-1:0]} + {{NB{1'b0}}, sub};
    dc_out = nib_s[NB];
    if (byte_mode) begin
      sum   = {a[W-1:H], half_s[H-1:0]};
      c_out = half_s[H];
      sa    = a[H-1];
      sb    = bx[H-1];
      sr    = half_s[H-1];
    end else begin
      sum   = full_s[W-1:0];
      c_out = full_s[W];
      sa    = a[W-1];
      sb    = bx[W-1];
      sr    = full_s[W-1];
    end
    ov_out = (sa == sb) && (sr != sa);
  end
endmodule

// File: rtl/alu_logshift.sv
module alu_logshift
  import status_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [3:0]   opcode,
  input  logic         byte_mode,
  output logic [W-1:0] res,
  output logic         c_out
);
  localparam int H = W / 2;

  logic [W-1:0] wr;
  logic         wc;
  logic [H-1:0] hr;
  logic         hc;
  logic [H-1:0] ha;
  logic [H-1:0] hb;

  always_comb begin
    ha = a[H-1:0];
    hb = b[H-1:0];
    wr = a; wc = 1'b0;
    hr = ha; hc = 1'b0;
    case (opcode)
      OP_AND: begin wr = a & b;  hr = ha & hb; end
      OP_OR:  begin wr = a | b;  hr = ha | hb; end
      OP_XOR: begin wr = a ^ b;  hr = ha ^ hb; end
      OP_SHL: begin
        wr = {a[W-2:0], 1'b0};  wc = a[W-1];
        hr = {ha[H-2:0], 1'b0}; hc = ha[H-1];
      end
      OP_SHR: begin
        wr = {1'b0, a[W-1:1]};  wc = a[0];
        hr = {1'b0, ha[H-1:1]}; hc = ha[0];
      end
      OP_ASR: begin
        wr = {a[W-1], a[W-1:1]};   wc = a[0];
        hr = {ha[H-1], ha[H-1:1]}; hc = ha[0];
      end
      default: ;
    endcase
    res   = byte_mode ? {a[W-1:H], hr} : wr;
    c_out = byte_mode ? hc : wc;
  end
endmodule

// File: rtl/alu_flagreg.sv
module alu_flagreg #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] upd,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bit_q <= 1'b0;
      else if (upd[i]) bit_q <= d[i];
    end
    assign q[i] = bit_q;
  end
endmodule

// File: rtl/status_alu.sv
module status_alu
  import status_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [3:0]   opcode,
  input  logic         byte_mode,
  input  logic         flag_en,
  output logic [W-1:0] result,
  output logic         flag_c,
  output logic         flag_z,
  output logic         flag_n,
  output logic         flag_ov,
  output logic         flag_dc
);
  localparam int H = W / 2;

  // named internal events
  logic              is_arith, is_sub, is_logic, is_shift;
  logic [NFLAGS-1:0] upd;
  logic [W-1:0]      as_res, ls_res;
  logic              as_c, as_ov, as_dc, ls_c;
  logic              z_now, n_now;
  logic [NFLAGS-1:0] flag_d, flag_q;

  alu_decode u_dec (
    .opcode(opcode), .flag_en(flag_en), .is_arith(is_arith), .is_sub(is_sub),
    .is_logic(is_logic), .is_shift(is_shift), .upd(upd)
  );

  alu_addsub #(.W(W)) u_as (
    .a(op_a), .b(op_b), .sub(is_sub), .byte_mode(byte_mode),
    .sum(as_res), .c_out(as_c), .ov_out(as_ov), .dc_out(as_dc)
  );

  alu_logshift #(.W(W)) u_ls (
    .a(op_a), .b(op_b), .opcode(opcode), .byte_mode(byte_mode),
    .res(ls_res), .c_out(ls_c)
  );

  always_comb begin
    if (is_arith)                 result = as_res;
    else if (is_logic || is_shift) result = ls_res;
    else                          result = op_a;
    z_now = byte_mode ? (result[H-1:0] == '0) : (result == '0);
    n_now = byte_mode ? result[H-1] : result[W-1];
    flag_d        = '0;
    flag_d[FB_C]  = is_arith ? as_c : ls_c;
    flag_d[FB_Z]  = z_now;
    flag_d[FB_N]  = n_now;
    flag_d[FB_OV] = as_ov;
    flag_d[FB_DC] = as_dc;
  end

  alu_flagreg #(.N(NFLAGS)) u_flags (
    .clk(clk), .rst_n(rst_n), .upd(upd), .d(flag_d), .q(flag_q)
  );

  assign flag_c  = flag_q[FB_C];
  assign flag_z  = flag_q[FB_Z];
  assign flag_n  = flag_q[FB_N];
  assign flag_ov = flag_q[FB_OV];
  assign flag_dc = flag_q[FB_DC];
endmodule

// File: rtl/status_alu_chk.sv
module status_alu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] op_a,
  input logic [3:0]  opcode,
  input logic        byte_mode,
  input logic        flag_en,
  input logic [15:0] result,
  input logic        flag_c,
  input logic        flag_z,
  input logic        flag_n,
  input logic        flag_ov,
  input logic        flag_dc,
  input logic        is_logic,
  input logic        is_shift
);
  logic [4:0] fl;
  assign fl = {flag_c, flag_z, flag_n, flag_ov, flag_dc};

  AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_en |=> $stable(fl)); // R9
  AST_LOGIC_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    is_logic |=> $stable(flag_c) && $stable(flag_ov) && $stable(flag_dc)); // R7
  AST_SHIFT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    is_shift |=> $stable(flag_ov) && $stable(flag_dc)); // R8
  AST_ZERO_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_en && opcode < 4'd8) |=>
      flag_z == ($past(byte_mode) ? ($past(result[7:0]) == 8'h00) : ($past(result) == 16'h0000))); // R5
  AST_NEG_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_en && opcode < 4'd8) |=>
      flag_n == ($past(byte_mode) ? $past(result[7]) : $past(result[15]))); // R5
  AST_BYTE_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    byte_mode |-> result[15:8] == op_a[15:8]); // R6
  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    opcode >= 4'd8 |-> result == op_a); // R11
  AST_PASS_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    opcode >= 4'd8 |=> $stable(fl)); // R11
endmodule

bind status_alu status_alu_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op_a(op_a), .opcode(opcode), .byte_mode(byte_mode),
  .flag_en(flag_en), .result(result), .flag_c(flag_c), .flag_z(flag_z),
  .flag_n(flag_n), .flag_ov(flag_ov), .flag_dc(flag_dc),
  .is_logic(is_logic), .is_shift(is_shift)
);

// File: tb/tb_status_alu.sv
module tb_status_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] op_a = '0, op_b = '0;
  logic [3:0]  opcode = 4'd15;
  logic        byte_mode = 1'b0, flag_en = 1'b0;
  logic [15:0] result;
  logic        flag_c, flag_z, flag_n, flag_ov, flag_dc;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  status_alu dut (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .opcode(opcode),
    .byte_mode(byte_mode), .flag_en(flag_en), .result(result),
    .flag_c(flag_c), .flag_z(flag_z), .flag_n(flag_n), .flag_ov(flag_ov),
    .flag_dc(flag_dc)
  );

  // {opcode, byte, A, B, expected result, expected flags C Z N OV DC}
  localparam int NV = 22;
  localparam logic [57:0] VEC [NV] = '{
    {4'd0, 1'b0, 16'h1234, 16'h1111, 16'h2345, 5'b00000}, // R1 plain add
    {4'd0, 1'b0, 16'hFFFF, 16'h0001, 16'h0000, 5'b11001}, // R1 R4 R5 carry out
    {4'd0, 1'b0, 16'h7FFF, 16'h0001, 16'h8000, 5'b00111}, // R3 positive overflow
    {4'd0, 1'b0, 16'h8000, 16'h8000, 16'h0000, 5'b11010}, // R3 negative overflow
    {4'd1, 1'b0, 16'h0005, 16'h0003, 16'h0002, 5'b10001}, // R2 R4 no borrow
    {4'd1, 1'b0, 16'h0003, 16'h0005, 16'hFFFE, 5'b00100}, // R2 borrow
    {4'd1, 1'b0, 16'h8000, 16'h0001, 16'h7FFF, 5'b10010}, // R3 subtract overflow
    {4'd1, 1'b0, 16'h1234, 16'h1234, 16'h0000, 5'b11001}, // R2 R5 equal
    {4'd0, 1'b1, 16'hAB7F, 16'h0001, 16'hAB80, 5'b00111}, // R6 byte overflow
    {4'd0, 1'b1, 16'h12FF, 16'h3401, 16'h1200, 5'b11001}, // R6 byte carry
    {4'd1, 1'b1, 16'h5510, 16'hFF20, 16'h55F0, 5'b00101}, // R6 R4 byte borrow
    {4'd2, 1'b0, 16'hF0F0, 16'h0FF0, 16'h00F0, 5'b00000}, // R7 and
    {4'd3, 1'b0, 16'h8000, 16'h0001, 16'h8001, 5'b00100}, // R7 or
    {4'd4, 1'b0, 16'hAAAA, 16'hAAAA, 16'h0000, 5'b01000}, // R7 xor
    {4'd5, 1'b0, 16'h8001, 16'h0000, 16'h0002, 5'b10000}, // R8 shl
    {4'd6, 1'b0, 16'h0001, 16'h0000, 16'h0000, 5'b11000}, // R8 shr
    {4'd7, 1'b0, 16'h8002, 16'h0000, 16'hC001, 5'b00100}, // R8 asr
    {4'd5, 1'b1, 16'h3480, 16'h0000, 16'h3400, 5'b11000}, // R8 R6 byte shl
    {4'd7, 1'b1, 16'h1281, 16'h0000, 16'h12C0, 5'b10100}, // R8 R6 byte asr
    {4'd6, 1'b1, 16'hFF80, 16'h0000, 16'hFF40, 5'b00000}, // R8 R6 byte shr
    {4'd2, 1'b1, 16'h12F0, 16'h0F0F, 16'h1200, 5'b01000}, // R7 R6 byte and
    {4'd9, 1'b0, 16'hBEEF, 16'h1234, 16'hBEEF, 5'b00000}  // R11 pass
  };
  string TAG [NV] = '{"R1", "R1/R4", "R3", "R3", "R2/R4", "R2", "R3", "R2/R5",
                      "R6", "R6", "R6/R4", "R7", "R7", "R7", "R8", "R8", "R8",
                      "R8/R6", "R8/R6", "R8/R6", "R7/R6", "R11"};

  // which flags each opcode owns, bench view: C Z N OV DC
  function automatic logic [4:0] owned(input logic [3:0] op);
    if (op <= 4'd1) return 5'b11111;
    if (op <= 4'd4) return 5'b01100;
    if (op <= 4'd7) return 5'b11100;
    return 5'b00000;
  endfunction

  function automatic logic [4:0] flags_now();
    return {flag_c, flag_z, flag_n, flag_ov, flag_dc};
  endfunction

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  logic [4:0] model;

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    model = 5'b00000;
    #5;
    check("R10", "flags in reset", {11'd0, flags_now()}, 16'h0000);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10", "flags after reset", {11'd0, flags_now()}, 16'h0000);

    flag_en = 1'b1;
    for (int i = 0; i < NV; i++) begin
      logic [57:0] v;
      v = VEC[i];
      opcode = v[57:54]; byte_mode = v[53]; op_a = v[52:37]; op_b = v[36:21];
      #1;
      check(TAG[i], "result", result, v[20:5]);
      check("R9", "flags before edge", {11'd0, flags_now()}, {11'd0, model});
      model = (model & ~owned(v[57:54])) | (v[4:0] & owned(v[57:54]));
      @(negedge clk);
      check(TAG[i], "flags", {11'd0, flags_now()}, {11'd0, model});
    end

    // R9: enable low, result still produced, flags hold
    flag_en = 1'b0; opcode = 4'd0; byte_mode = 1'b0; op_a = 16'hFFFF; op_b = 16'h0001;
    #1;
    check("R9", "result with enable low", result, 16'h0000);
    @(negedge clk);
    check("R9", "flags held with enable low", {11'd0, flags_now()}, {11'd0, model});

    // build non-zero flags, then R10 reset mid-run
    flag_en = 1'b1; opcode = 4'd0; op_a = 16'h8000; op_b = 16'h8000;
    @(negedge clk);
    check("R3", "setup flags", {11'd0, flags_now()}, 16'h001A);
    // R11 with byte mode: whole A passes, flags kept
    opcode = 4'd15; byte_mode = 1'b1; op_a = 16'h5A0F;
    #1;
    check("R11", "pass result byte", result, 16'h5A0F);
    @(negedge clk);
    check("R11", "pass keeps flags", {11'd0, flags_now()}, 16'h001A);
    rst_n = 1'b0;
    #1;
    check("R10", "async clear", {11'd0, flags_now()}, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule